// File: doc/BRIEF.md
# Multi-mode pulse counter channel with set-point comparators

This block is a single channel of an industrial pulse-input counter. Phase A, phase B, gate, marker and limit lines arrive already converted to logic levels. Each one passes through a two-flop synchronizer. A phase decoder state machine turns the synchronized A/B pair into at most one up or down step per clock. The mode input selects how it does this:

- single-phase normal: one count per pulse.
- single-phase both-edge: two counts per pulse.
- two-phase quadrature: counts up or down, with the direction taken from the phase order.

The steps feed an unsigned wrapping count register. That register is qualified by the gate and limit lines and cleared by a marker rising edge.

Two set-points are loaded through a plain write port. Two registered compare outputs follow the count. One goes high when the count is strictly above the first set-point. The other goes high when the count is strictly below the second. The live count is available for read on `count_o`.

The decoder state machine holds the last sampled phase pair. Its states are `PH_00`, `PH_10`, `PH_11` and `PH_01`, each named as `{A,B}`. Each clock it moves to the newly sampled pair, and every move falls into one of four transitions:

- **forward** (`PH_00→PH_10→PH_11→PH_01→PH_00`, A leading B): an up step in quadrature mode.
- **backward** (the reverse order): a down step in quadrature mode.
- **skip** (both phases changed at once): no step in quadrature mode.
- **hold** (no change): no step in any mode.

In the single-phase modes, only the A bit of the old and new state matters.

Top module: `pulse_counter_ch`

## Requirements
- R1: After reset the following are all 0: `count_o`, both set-points, `cmp_gt_o` and `cmp_lt_o`.
- R2: With `mode_i`=0 (normal), the count rises by one on each rising edge of phase A. A falling edge of A has no effect on the count, and phase B has no effect on the count.
- R3: With `mode_i`=1 (both-edge), the count rises by one on every rising and every falling edge of phase A.
- R4: With `mode_i`=2 (quadrature), the `{A,B}` order 00→10→11→01→00 counts up by one per transition, and the reverse order counts down by one. A change of both phases in one sample gives no step. With `mode_i`=3, the count is held.
- R5: The count is 24 bits wide and wraps. A step down from 0 gives 16777215, and a step up from 16777215 gives 0.
- R6: While the synchronized gate input is low, no step changes the count.
- R7: While the synchronized limit input is high, no step changes the count.
- R8: A rising edge of the synchronized marker input sets the count to 0, even when a step occurs in the same cycle. A marker held high does not clear again.
- R9: `cmp_gt_o` is 1 exactly when the count is strictly greater than set-point 1. It shows the count and set-point values of the previous clock.
- R10: `cmp_lt_o` is 1 exactly when the count is strictly less than set-point 2. It shows the count and set-point values of the previous clock.
- R11: Suppose an input change is first sampled at clock edge k. The count then reflects it at edge k+2, and not earlier.
- R12: A write with `wr_en_i`=1 loads `wr_data_i` into set-point 1 when `wr_sel_i`=0, or into set-point 2 when `wr_sel_i`=1. The new value is active from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| mode_i | input | 2 | 0 normal, 1 both-edge, 2 quadrature, 3 hold |
| phase_a_i | input | 1 | Phase A pulse input, asynchronous |
| phase_b_i | input | 1 | Phase B pulse input, asynchronous |
| gate_i | input | 1 | Count enable while high, asynchronous |
| marker_i | input | 1 | Rising edge clears the count, asynchronous |
| limit_i | input | 1 | Inhibits counting while high, asynchronous |
| wr_en_i | input | 1 | Set-point write strobe |
| wr_sel_i | input | 1 | Set-point select: 0 = set-point 1, 1 = set-point 2 |
| wr_data_i | input | 24 | Set-point write value |
| count_o | output | 24 | Current count value |
| cmp_gt_o | output | 1 | High when count > set-point 1 (registered) |
| cmp_lt_o | output | 1 | High when count < set-point 2 (registered) |

## Verification
Suppose an input line changes while the clock is low, and the next rising edge is k. The count moves at edge k+2, and the compare outputs follow at edge k+3. A set-point write at edge k shows on the compare outputs at edge k+1.

Each vector from the table is held for four clock periods before the count and compares are sampled on a falling edge, so all results have settled. Directed tests sample the count on the falling edges after k, k+1 and k+2, and the compares on the falling edges after a write, to show that each result lands on exactly the cycle it is due.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_BOTH   = 2'd1,
        MODE_QUAD   = 2'd2,
        MODE_HOLD   = 2'd3
    } cnt_mode_e;

    // phase state named {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcnt_decode.sv
module pcnt_decode
    import pcnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cnt_mode_e mode_i,
    input  logic      a_i,
    input  logic      b_i,
    output step_t     step_o
);

    phase_e phase_q;
    phase_e phase_d;
    logic   prev_a;

    assign phase_d = phase_e'({a_i, b_i});
    assign prev_a  = phase_q[1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_00;
        else        phase_q <= phase_d;
    end

    // outputs: step decision from current state and new sample
    always_comb begin
        step_o = '0;
        unique case (mode_i)
            MODE_NORMAL: step_o.up = a_i & ~prev_a;
            MODE_BOTH:   step_o.up = a_i ^ prev_a;
            MODE_QUAD: begin
                unique case (phase_q)
                    PH_00: begin
                        step_o.up = (phase_d == PH_10);
                        step_o.dn = (phase_d == PH_01);
                    end
                    PH_10: begin
                        step_o.up = (phase_d == PH_11);
                        step_o.dn = (phase_d == PH_00);
                    end
                    PH_11: begin
                        step_o.up = (phase_d == PH_01);
                        step_o.dn = (phase_d == PH_10);
                    end
                    PH_01: begin
                        step_o.up = (phase_d == PH_00);
                        step_o.dn = (phase_d == PH_11);
                    end
                endcase
            end
            MODE_HOLD: step_o = '0;
        endcase
    end

endmodule

// File: rtl/pcnt_counter.sv
module pcnt_counter
    import pcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step_i,
    input  logic             en_i,
    input  logic             marker_i,
    output logic             clear_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic marker_prev_q;
    logic [CNT_W-1:0] count_q;

    assign clear_o = marker_i & ~marker_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) marker_prev_q <= 1'b0;
        else        marker_prev_q <= marker_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   count_q <= '0;
        else if (clear_o)             count_q <= '0;
        else if (en_i && step_i.up)   count_q <= count_q + ONE;
        else if (en_i && step_i.dn)   count_q <= count_q - ONE;
    end

    assign count_o = count_q;

endmodule

// File: rtl/pcnt_compare.sv
module pcnt_compare #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] sp1_o,
    output logic [CNT_W-1:0] sp2_o,
    output logic             gt_o,
    output logic             lt_o
);

    logic [CNT_W-1:0] sp1_q, sp2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp1_q <= '0;
            sp2_q <= '0;
        end else if (wr_en_i) begin
            if (wr_sel_i) sp2_q <= wr_data_i;
            else          sp1_q <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gt_o <= 1'b0;
            lt_o <= 1'b0;
        end else begin
            gt_o <= (count_i > sp1_q);
            lt_o <= (count_i < sp2_q);
        end
    end

    assign sp1_o = sp1_q;
    assign sp2_o = sp2_q;

endmodule

// File: rtl/pulse_counter_ch.sv
module pulse_counter_ch
    import pcnt_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             phase_a_i,
    input  logic             phase_b_i,
    input  logic             gate_i,
    input  logic             marker_i,
    input  logic             limit_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             cmp_gt_o,
    output logic             cmp_lt_o
);

    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in, syn_in;
    logic a_s, b_s, gate_s, marker_s, limit_s;
    step_t step;
    logic cnt_en;
    logic clear_evt;
    logic [CNT_W-1:0] sp1_q, sp2_q;

    assign raw_in = {marker_i, limit_i, gate_i, phase_b_i, phase_a_i};
    assign {marker_s, limit_s, gate_s, b_s, a_s} = syn_in;
    assign cnt_en = gate_s & ~limit_s;

    pcnt_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    pcnt_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (cnt_mode_e'(mode_i)),
        .a_i    (a_s),
        .b_i    (b_s),
        .step_o (step)
    );

    pcnt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .en_i     (cnt_en),
        .marker_i (marker_s),
        .clear_o  (clear_evt),
        .count_o  (count_o)
    );

    pcnt_compare #(.CNT_W(CNT_W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .count_i   (count_o),
        .sp1_o     (sp1_q),
        .sp2_o     (sp2_q),
        .gt_o      (cmp_gt_o),
        .lt_o      (cmp_lt_o)
    );

endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk
    import pcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_o,
    input logic             cmp_gt_o,
    input logic             cmp_lt_o,
    input step_t            step,
    input logic             cnt_en,
    input logic             clear_evt,
    input logic [CNT_W-1:0] sp1_q,
    input logic [CNT_W-1:0] sp2_q
);

    // R4
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step.up, step.dn}));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step.up && cnt_en && !clear_evt) |=> count_o == CNT_W'($past(count_o) + CNT_W'(1)));

    // R5
    step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step.dn && cnt_en && !clear_evt) |=> count_o == CNT_W'($past(count_o) - CNT_W'(1)));

    // R6
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !clear_evt) |=> $stable(count_o));

    // R8
    clear_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_evt |=> count_o == '0);

    // R9
    cmp_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cmp_gt_o == ($past(count_o) > $past(sp1_q)));

    // R10
    cmp_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cmp_lt_o == ($past(count_o) < $past(sp2_q)));

endmodule

bind pulse_counter_ch pcnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_o   (count_o),
    .cmp_gt_o  (cmp_gt_o),
    .cmp_lt_o  (cmp_lt_o),
    .step      (step),
    .cnt_en    (cnt_en),
    .clear_evt (clear_evt),
    .sp1_q     (sp1_q),
    .sp2_q     (sp2_q)
);

// File: tb/pulse_counter_ch_bench.sv
module pulse_counter_ch_bench;

    localparam int W = 24;
    localparam int NV = 20;
    localparam logic [W-1:0] SP1 = 24'd3;
    localparam logic [W-1:0] SP2 = 24'd2;

    // vector fields: {mode[2], a, b, gate, limit, marker, pad, expected_count[24]}
    localparam logic [31:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'd1},
        {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'd1},
        {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'd2},
        {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'd2},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'd3},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'd4},
        {2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'd5},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'd6},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'd7},
        {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'd8},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'd7},
        {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'd7},
        {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 24'd7},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 24'd7},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 24'd0},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 24'd1},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'd0},
        {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'hFFFFFF},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'd0},
        {2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 24'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic pa = 1'b0, pb = 1'b0, gate = 1'b0, marker = 1'b0, limit = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic gt, lt;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pulse_counter_ch u_pulse_counter_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .phase_a_i (pa),
        .phase_b_i (pb),
        .gate_i    (gate),
        .marker_i  (marker),
        .limit_i   (limit),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .count_o   (count),
        .cmp_gt_o  (gt),
        .cmp_lt_o  (lt)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2, 3, 4:       return "R2";
            5, 6:                return "R3";
            12:                  return "R6";
            13:                  return "R7";
            14, 15:              return "R8";
            17, 18:              return "R5";
            default:             return "R4";
        endcase
    endfunction

    task automatic write_sp(input logic sel, input logic [W-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "count", count, '0);
        check("R1", "gt", {23'd0, gt}, '0);
        check("R1", "lt", {23'd0, lt}, '0);

        // R12 load set-points
        write_sp(1'b0, SP1);
        write_sp(1'b1, SP2);
        gate = 1'b1;
        repeat (4) @(negedge clk);
        check("R12", "lt after sp2 load", {23'd0, lt}, 24'd1);
        check("R12", "gt after sp1 load", {23'd0, gt}, 24'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode   = VEC[i][31:30];
            pa     = VEC[i][29];
            pb     = VEC[i][28];
            gate   = VEC[i][27];
            limit  = VEC[i][26];
            marker = VEC[i][25];
            repeat (4) @(negedge clk);
            check(vec_tag(i), $sformatf("count v%0d", i), count, VEC[i][W-1:0]);
            check("R9",  $sformatf("gt v%0d", i), {23'd0, gt},
                  {23'd0, (VEC[i][W-1:0] > SP1)});
            check("R10", $sformatf("lt v%0d", i), {23'd0, lt},
                  {23'd0, (VEC[i][W-1:0] < SP2)});
        end

        // R11 exact count latency, normal mode, count 0 -> 1
        @(negedge clk);
        mode = 2'd0; pa = 1'b0; marker = 1'b0;
        repeat (4) @(negedge clk);
        pa = 1'b1;
        @(negedge clk);
        check("R11", "count after k", count, 24'd0);
        @(negedge clk);
        check("R11", "count after k+1", count, 24'd0);
        @(negedge clk);
        check("R11", "count after k+2", count, 24'd1);
        @(negedge clk);
        check("R10", "lt one after count", {23'd0, lt}, 24'd1);

        // R12 write latency on sp2: 1 < 1 is false
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 24'd1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R12", "lt before settle", {23'd0, lt}, 24'd1);
        @(negedge clk);
        check("R12", "lt after sp2=1", {23'd0, lt}, 24'd0);

        // R12 write on sp1: 1 > 0
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 24'd0;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9", "gt before settle", {23'd0, gt}, 24'd0);
        @(negedge clk);
        check("R12", "gt after sp1=0", {23'd0, gt}, 24'd1);

        // R1 reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "count after re-reset", count, '0);
        check("R1", "gt after re-reset", {23'd0, gt}, '0);
        check("R1", "lt after re-reset", {23'd0, lt}, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule